// File: doc/BRIEF.md
# Width-Aware Condition Flag Unit

This block is the integer execute slice of a two-operand machine that keeps condition codes. Each valid operation combines two operands (or, for increment and decrement, the current destination value and one) at a selected width of one, two or four bytes. It returns the destination word with only the selected low bytes replaced, and it latches sign, zero, carry and parity flags computed at that width. A compare behaves like a subtraction for the flags but leaves the destination unchanged.

Branch resolution uses the stored flags. When the branch enable is raised, the unit tests the requested condition against the flag register, plus a signed-overflow bit kept internally, and drives a taken signal in the same cycle. A branch with no flag-setting operation just before it uses whatever flags were latched last.

Top module: `ccFlagUnit`

## Requirements
- R1: Opcode encoding is 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 increment, 7 decrement. For add, subtract and the three logic operations, the low bytes of `dstOut` carry `srcA op srcB` truncated to the selected width, in the same cycle as `opValid`.
- R2: Width encoding is 00 for one byte, 01 for two bytes, 10 or 11 for four bytes. Bytes of `dstOut` above the selected width always equal `dstPrev`.
- R3: Increment and decrement take `dstPrev` as their operand, ignore `srcA` and `srcB`, and add or subtract one, wrapping within the selected width.
- R4: The latched sign flag is the top bit of the width-limited result. The latched zero flag is set when the width-limited result is all zeros.
- R5: Carry is the carry out of the top selected bit for add and increment. For subtract, compare and decrement it is the unsigned borrow. AND, OR and XOR clear it.
- R6: The latched parity flag is 1 when bits 7..0 of the result hold an even number of ones.
- R7: Compare updates the flags as subtract does, holds `dstWrite` low and passes `dstPrev` through unchanged. Every other valid operation drives `dstWrite` high. When `opValid` is low, `dstWrite` is low and `dstOut` equals `dstPrev`.
- R8: Flags load on the rising edge at which `opValid` is high and hold otherwise. Reset clears all flags.
- R9: With `brEn` high, condition 0 (equal) is taken when zero is set and condition 1 (not equal) is taken when zero is clear.
- R10: Signed conditions use sign XOR overflow (called `lt`): 2 less is `lt`, 3 less-or-equal is `lt` or zero, 4 greater is neither, 5 greater-or-equal is not `lt`. Codes 6 and 7 are never taken, and `brTaken` is low whenever `brEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Operation select (R1 encoding) |
| opWidth | input | 2 | Operation width select (R2 encoding) |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| dstPrev | input | 32 | Current destination value |
| brEn | input | 1 | Evaluate a branch condition |
| brCond | input | 3 | Branch condition select (R9/R10 encoding) |
| dstOut | output | 32 | Merged destination value |
| dstWrite | output | 1 | Destination should be written |
| flagSign | output | 1 | Stored sign flag |
| flagZero | output | 1 | Stored zero flag |
| flagCarry | output | 1 | Stored carry flag |
| flagParity | output | 1 | Stored parity flag |
| brTaken | output | 1 | Branch condition holds |

## Verification
The bench builds the unit with its default 32-bit data width. At that width all three operation sizes are available, so a single run covers byte wrap, halfword borrow and full-word carry, along with the merge of upper bytes from the previous destination at each narrow width. Signed branch tests use byte-wide compares in which the sign flag alone gives the wrong answer, so the internally tracked overflow bit has to be correct for the branch to resolve correctly.

// File: rtl/ccFlagPkg.sv
package ccFlagPkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_INC = 3'd6,
    OP_DEC = 3'd7
  } opKind_e;

  typedef enum logic [2:0] {
    BR_EQ   = 3'd0,
    BR_NE   = 3'd1,
    BR_LT   = 3'd2,
    BR_LE   = 3'd3,
    BR_GT   = 3'd4,
    BR_GE   = 3'd5,
    BR_RSV6 = 3'd6,
    BR_RSV7 = 3'd7
  } brKind_e;

  typedef enum logic [1:0] {
    LOG_AND  = 2'd0,
    LOG_OR   = 2'd1,
    LOG_XOR  = 2'd2,
    LOG_NONE = 2'd3
  } logicSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      useDst;   // operand A is dstPrev, operand B is one
    logic      doSub;    // arithmetic path subtracts
    logic      isLogic;  // result comes from the logic path
    logicSel_e logicSel;
    logic      writeDst;
    logic      updFlags;
  } ctrlStrobe_t;

  typedef struct packed {
    logic sign;
    logic zero;
    logic carry;
    logic parity;
    logic ovf;
  } flagSet_t;

endpackage

// File: rtl/ccFlagCtrl.sv
module ccFlagCtrl
  import ccFlagPkg::*;
(
  input  logic        opValid,
  input  opKind_e     opCode,
  input  logic        brEn,
  input  brKind_e     brCond,
  input  logic        flagSign,
  input  logic        flagZero,
  input  logic        flagOvf,
  output ctrlStrobe_t strobe,
  output logic        brTaken
);

  // operation decode
  always_comb begin
    strobe          = '0;
    strobe.logicSel = LOG_NONE;
    strobe.updFlags = opValid;
    strobe.writeDst = opValid && (opCode != OP_CMP);
    unique case (opCode)
      OP_ADD: ;
      OP_SUB: strobe.doSub = 1'b1;
      OP_CMP: strobe.doSub = 1'b1;
      OP_AND: begin strobe.isLogic = 1'b1; strobe.logicSel = LOG_AND; end
      OP_OR:  begin strobe.isLogic = 1'b1; strobe.logicSel = LOG_OR;  end
      OP_XOR: begin strobe.isLogic = 1'b1; strobe.logicSel = LOG_XOR; end
      OP_INC: strobe.useDst = 1'b1;
      OP_DEC: begin strobe.useDst = 1'b1; strobe.doSub = 1'b1; end
      default: ;
    endcase
  end

  // branch condition evaluation on stored flags
  logic signedLess;
  logic condHit;

  assign signedLess = flagSign ^ flagOvf;

  always_comb begin
    unique case (brCond)
      BR_EQ:   condHit = flagZero;
      BR_NE:   condHit = !flagZero;
      BR_LT:   condHit = signedLess;
      BR_LE:   condHit = signedLess || flagZero;
      BR_GT:   condHit = !signedLess && !flagZero;
      BR_GE:   condHit = !signedLess;
      default: condHit = 1'b0;
    endcase
  end

  assign brTaken = brEn && condHit;

endmodule

// File: rtl/ccFlagPath.sv
module ccFlagPath
  import ccFlagPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        wSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] dstPrev,
  output logic [DATA_W-1:0] dstOut,
  output logic              dstWrite,
  output flagSet_t          flagQ
);

  localparam int NBYTES = DATA_W / 8;
  localparam int BCNT_W = $clog2(NBYTES + 1);
  localparam int IDX_W  = $clog2(DATA_W + 1);

  logic [BCNT_W-1:0] activeBytes;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  carryIdx;
  logic [NBYTES-1:0] byteLive;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] aM;
  logic [DATA_W-1:0] bM;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] resM;
  logic [DATA_W:0]   sumW;
  logic [DATA_W:0]   diffW;
  logic [DATA_W:0]   arithW;
  logic              aTop;
  logic              bTop;
  logic              rTop;
  flagSet_t          flagNext;

  // width decode
  always_comb begin
    unique case (wSel)
      2'b00: begin activeBytes = BCNT_W'(1); topIdx = IDX_W'(7);  end
      2'b01: begin activeBytes = BCNT_W'(2); topIdx = IDX_W'(15); end
      default: begin
        activeBytes = BCNT_W'(NBYTES);
        topIdx      = IDX_W'(DATA_W - 1);
      end
    endcase
  end

  assign carryIdx = topIdx + IDX_W'(1);

  // per-byte lane mask and destination merge
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign byteLive[i]      = activeBytes > BCNT_W'(i);
    assign mask[8*i +: 8]   = {8{byteLive[i]}};
    assign dstOut[8*i +: 8] = (strobe.writeDst && byteLive[i]) ? resM[8*i +: 8]
                                                               : dstPrev[8*i +: 8];
  end

  assign dstWrite = strobe.writeDst;

  // operand selection
  assign opA = strobe.useDst ? dstPrev : srcA;
  assign opB = strobe.useDst ? DATA_W'(1) : srcB;
  assign aM  = opA & mask;
  assign bM  = opB & mask;

  // arithmetic: masked operands, so bit carryIdx is the carry or borrow
  assign sumW   = {1'b0, aM} + {1'b0, bM};
  assign diffW  = {1'b0, aM} - {1'b0, bM};
  assign arithW = strobe.doSub ? diffW : sumW;

  always_comb begin
    unique case (strobe.logicSel)
      LOG_AND: logicRes = aM & bM;
      LOG_OR:  logicRes = aM | bM;
      LOG_XOR: logicRes = aM ^ bM;
      default: logicRes = '0;
    endcase
  end

  assign resM = (strobe.isLogic ? logicRes : arithW[DATA_W-1:0]) & mask;

  assign aTop = aM[topIdx];
  assign bTop = bM[topIdx];
  assign rTop = resM[topIdx];

  always_comb begin
    flagNext.sign   = rTop;
    flagNext.zero   = ~|resM;
    flagNext.parity = ~^resM[7:0];
    if (strobe.isLogic) begin
      flagNext.carry = 1'b0;
      flagNext.ovf   = 1'b0;
    end else begin
      flagNext.carry = arithW[carryIdx];
      flagNext.ovf   = strobe.doSub ? ((aTop != bTop) && (rTop != aTop))
                                    : ((aTop == bTop) && (rTop != aTop));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                flagQ <= '0;
    else if (strobe.updFlags) flagQ <= flagNext;
  end

  assert_narrow_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wSel == 2'b00) |-> (dstOut[DATA_W-1:8] == dstPrev[DATA_W-1:8]));

  assert_nowrite_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dstWrite |-> (dstOut == dstPrev));

  assert_logic_clears_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.updFlags && strobe.isLogic) |=> !flagQ.carry);

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.updFlags |=> $stable(flagQ));

endmodule

// File: rtl/ccFlagUnit.sv
module ccFlagUnit
  import ccFlagPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [1:0]        opWidth,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] dstPrev,
  input  logic              brEn,
  input  logic [2:0]        brCond,
  output logic [DATA_W-1:0] dstOut,
  output logic              dstWrite,
  output logic              flagSign,
  output logic              flagZero,
  output logic              flagCarry,
  output logic              flagParity,
  output logic              brTaken
);

  ctrlStrobe_t strobe;
  flagSet_t    flagQ;

  ccFlagCtrl u_ctrl (
    .opValid  (opValid),
    .opCode   (opKind_e'(opCode)),
    .brEn     (brEn),
    .brCond   (brKind_e'(brCond)),
    .flagSign (flagQ.sign),
    .flagZero (flagQ.zero),
    .flagOvf  (flagQ.ovf),
    .strobe   (strobe),
    .brTaken  (brTaken)
  );

  ccFlagPath #(.DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wSel     (opWidth),
    .srcA     (srcA),
    .srcB     (srcB),
    .dstPrev  (dstPrev),
    .dstOut   (dstOut),
    .dstWrite (dstWrite),
    .flagQ    (flagQ)
  );

  assign flagSign   = flagQ.sign;
  assign flagZero   = flagQ.zero;
  assign flagCarry  = flagQ.carry;
  assign flagParity = flagQ.parity;

  assert_branch_eq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (brEn && brCond == 3'd0) |-> (brTaken == flagZero));

  assert_branch_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !brEn |-> !brTaken);

endmodule

// File: tb/ccFlagUnit_tb.sv
`timescale 1ns/1ps
module ccFlagUnit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  opWidth = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] dstPrev = '0;
  logic        brEn = 1'b0;
  logic [2:0]  brCond = '0;
  logic [31:0] dstOut;
  logic        dstWrite;
  logic        flagSign, flagZero, flagCarry, flagParity, brTaken;

  int testCount = 0;
  int failCount = 0;

  // expected stored flags, tracked by the bench
  logic eS = 0, eZ = 0, eC = 0, eP = 0, eV = 0;

  always #2.5 clk = ~clk;

  ccFlagUnit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opWidth(opWidth),
    .srcA(srcA), .srcB(srcB), .dstPrev(dstPrev), .brEn(brEn), .brCond(brCond),
    .dstOut(dstOut), .dstWrite(dstWrite), .flagSign(flagSign), .flagZero(flagZero),
    .flagCarry(flagCarry), .flagParity(flagParity), .brTaken(brTaken)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input logic [2:0] op, input logic [1:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] prev,
                       output logic [31:0] merged, output logic wr,
                       output logic s, output logic z, output logic c,
                       output logic p, output logic v);
    int n;
    logic [63:0] mask, x, y, r, rm;
    logic xs, ys, rs;
    n    = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    mask = (64'h1 << n) - 64'h1;
    x    = ((op == 3'd6 || op == 3'd7) ? {32'h0, prev} : {32'h0, a}) & mask;
    y    = ((op == 3'd6 || op == 3'd7) ? 64'h1 : {32'h0, b}) & mask;
    c = 0; v = 0;
    case (op)
      3'd0, 3'd6: begin r = x + y; c = r[n]; end
      3'd1, 3'd2, 3'd7: begin r = x - y; c = (x < y); end
      3'd3: r = x & y;
      3'd4: r = x | y;
      default: r = x ^ y;
    endcase
    rm = r & mask;
    xs = x[n-1]; ys = y[n-1]; rs = rm[n-1];
    if (op == 3'd0 || op == 3'd6) v = (xs == ys) && (rs != xs);
    if (op == 3'd1 || op == 3'd2 || op == 3'd7) v = (xs != ys) && (rs != xs);
    s = rs;
    z = (rm == 64'h0);
    p = ~^rm[7:0];
    wr = (op != 3'd2);
    merged = wr ? ((prev & ~mask[31:0]) | rm[31:0]) : prev;
  endtask

  function automatic logic brExp(input logic [2:0] cond);
    logic lt;
    lt = eS ^ eV;
    case (cond)
      3'd0: return eZ;
      3'd1: return !eZ;
      3'd2: return lt;
      3'd3: return lt || eZ;
      3'd4: return !lt && !eZ;
      3'd5: return !lt;
      default: return 1'b0;
    endcase
  endfunction

  // present one operation, check the merged value, then the latched flags
  task automatic runOp(input string tag, input logic [2:0] op, input logic [1:0] w,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] prev);
    logic [31:0] expDst;
    logic expWr, s, z, c, p, v;
    model(op, w, a, b, prev, expDst, expWr, s, z, c, p, v);
    @(negedge clk);
    opValid = 1; opCode = op; opWidth = w; srcA = a; srcB = b; dstPrev = prev;
    #1;
    chk(tag, "dstOut", dstOut, expDst);
    chk("R7", "dstWrite", {31'h0, dstWrite}, {31'h0, expWr});
    @(negedge clk);
    opValid = 0;
    eS = s; eZ = z; eC = c; eP = p; eV = v;
    #1;
    chk("R4", "sign", {31'h0, flagSign}, {31'h0, eS});
    chk("R4", "zero", {31'h0, flagZero}, {31'h0, eZ});
    chk("R5", "carry", {31'h0, flagCarry}, {31'h0, eC});
    chk("R6", "parity", {31'h0, flagParity}, {31'h0, eP});
  endtask

  task automatic checkBranch(input string tag, input logic [2:0] cond);
    brEn = 1; brCond = cond;
    #1;
    chk(tag, "brTaken", {31'h0, brTaken}, {31'h0, brExp(cond)});
    brEn = 0;
    #1;
    chk("R10", "brTaken idle", {31'h0, brTaken}, 32'h0);
  endtask

  task automatic tReset();
    #1;
    chk("R8", "reset sign", {31'h0, flagSign}, 32'h0);
    chk("R8", "reset zero", {31'h0, flagZero}, 32'h0);
    chk("R8", "reset carry", {31'h0, flagCarry}, 32'h0);
    chk("R8", "reset parity", {31'h0, flagParity}, 32'h0);
    checkBranch("R9", 3'd0);
  endtask

  task automatic tArith();
    runOp("R1", 3'd0, 2'b10, 32'hFFFF_FFFF, 32'h1, 32'h1234_5678);     // word add wraps to zero
    runOp("R1", 3'd0, 2'b10, 32'h1000_0001, 32'h2000_0002, 32'h0);
    runOp("R2", 3'd0, 2'b00, 32'h0000_007F, 32'h0000_0001, 32'hAABB_CC00); // byte into upper kept
    runOp("R2", 3'd1, 2'b01, 32'h5555_0000, 32'h0000_0001, 32'hDEAD_BEEF); // half borrow
    runOp("R1", 3'd1, 2'b10, 32'h0000_0010, 32'h0000_0003, 32'h0);
  endtask

  task automatic tIncDec();
    runOp("R3", 3'd6, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_56FF); // byte inc wraps
    runOp("R3", 3'd7, 2'b01, 32'h0, 32'h0, 32'h0001_0000);                 // half dec borrows
    runOp("R3", 3'd6, 2'b10, 32'h0, 32'h0, 32'h7FFF_FFFF);
    runOp("R3", 3'd7, 2'b10, 32'h0, 32'h0, 32'h0000_0001);
  endtask

  task automatic tLogic();
    runOp("R1", 3'd0, 2'b00, 32'hFF, 32'hFF, 32'h0);                   // sets carry first
    runOp("R5", 3'd3, 2'b10, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0);     // AND clears it
    runOp("R5", 3'd4, 2'b01, 32'h0000_1200, 32'h0000_0034, 32'hCAFE_0000);
    runOp("R6", 3'd5, 2'b00, 32'h0000_0005, 32'h0000_0006, 32'h0);     // 0x03 even parity
    runOp("R6", 3'd5, 2'b00, 32'h0000_0003, 32'h0000_0002, 32'h0);     // 0x01 odd parity
  endtask

  task automatic tCompare();
    runOp("R7", 3'd2, 2'b10, 32'd5, 32'd7, 32'h0BAD_F00D);
    checkBranch("R9", 3'd1);
    checkBranch("R10", 3'd2);
    checkBranch("R10", 3'd4);
    runOp("R7", 3'd2, 2'b01, 32'h0000_4242, 32'h0000_4242, 32'h1111_2222);
    checkBranch("R9", 3'd0);
    checkBranch("R10", 3'd3);
    checkBranch("R10", 3'd5);
    checkBranch("R10", 3'd6);
  endtask

  task automatic tSigned();
    // -128 vs 1 at byte width: result 0x7F, sign clear, overflow set
    runOp("R10", 3'd2, 2'b00, 32'h0000_0080, 32'h0000_0001, 32'h0);
    checkBranch("R10", 3'd2);
    checkBranch("R10", 3'd5);
    // 127 vs -1 at byte width: result 0x80, sign set, overflow set
    runOp("R10", 3'd2, 2'b00, 32'h0000_007F, 32'h0000_00FF, 32'h0);
    checkBranch("R10", 3'd4);
    checkBranch("R10", 3'd3);
    checkBranch("R10", 3'd7);
  endtask

  task automatic tHold();
    runOp("R1", 3'd0, 2'b10, 32'h8000_0000, 32'h8000_0000, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      opCode = 3'd3; opWidth = 2'b00; srcA = 32'h1 << k; srcB = 32'hFF; dstPrev = 32'hA5A5_0000 + k;
      #1;
      chk("R7", "idle passthru", dstOut, dstPrev);
      chk("R7", "idle dstWrite", {31'h0, dstWrite}, 32'h0);
    end
    @(negedge clk);
    #1;
    chk("R8", "hold zero", {31'h0, flagZero}, {31'h0, eZ});
    chk("R8", "hold carry", {31'h0, flagCarry}, {31'h0, eC});
    checkBranch("R9", 3'd0);
  endtask

  initial begin
    #1_000_000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tArith();
    tIncDec();
    tLogic();
    tCompare();
    tSigned();
    tHold();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule